// File: doc/BRIEF.md
# Converter Output Capture and Derandomizer

This block sits directly behind the parallel data pins of a 14-bit sampling converter. It turns what arrives there back into the true sample stream. The converter's output clock is modelled as a synchronous capture enable, `cap_en`. On each enabled edge the block registers one bus, or both buses, together with their overflow flags.

In full-rate operation only bus A carries data, and each capture yields one sample. In demultiplexed operation the two buses each carry a sample at half the encode rate. The block then serializes each captured pair: the bus A sample goes out first and the bus B sample follows on the next cycle. Each output sample keeps the overflow flag of its own bus.

The converter can optionally scramble its output. In that case every bit above the LSB has been XORed with the LSB. When `rand_en` is high the block reverses this before the data is registered. A sticky status bit remembers that any flagged sample was emitted, and `ovf_clear` clears it.

Top module: `adc_capture_derand`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `ovf_sticky` are 0.
- R2: With `rand_en` low at the capture edge, the emitted sample equals the captured bus word bit for bit, and `out_ovf` equals the captured overflow bit.
- R3: With `rand_en` high at the capture edge, emitted bit i (i from 1 to 13) equals received bit i XOR received bit 0. Bit 0 and the overflow flag are emitted unchanged.
- R4: In full-rate mode (`demux_mode` = 0), a capture sampled at edge n makes `out_valid` high with the bus A sample for exactly one cycle after edge n+1. Bus B and its overflow bit never reach the output.
- R5: In demultiplexed mode (`demux_mode` = 1), a capture sampled at edge n emits the bus A sample after edge n+1 and the bus B sample after edge n+2. Each carries its own bus's overflow bit.
- R6: In demultiplexed mode, a `cap_en` in the cycle right after an accepted capture is ignored and produces no output.
- R7: The active mode reloads from `demux_mode` only in a cycle with no captured pair in flight and no bus B sample pending. While `demux_mode` differs from the active mode, `cap_en` is ignored and a pending bus B sample is dropped without being emitted. The bus A sample already captured is still emitted.
- R8: `ovf_sticky` goes high the edge after a cycle in which `out_valid` and `out_ovf` are both high, and it then stays high.
- R9: `ovf_clear` high at an edge clears `ovf_sticky`, unless a flagged sample is being emitted in that same cycle; in that case the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture strobe standing in for the converter output clock |
| demux_mode | input | 1 | 0 = full-rate single bus, 1 = two half-rate buses |
| rand_en | input | 1 | 1 = incoming data is scrambled and must be decoded |
| a_data | input | 14 | Bus A data word |
| a_ovf | input | 1 | Bus A out-of-range flag |
| b_data | input | 14 | Bus B data word |
| b_ovf | input | 1 | Bus B out-of-range flag |
| ovf_clear | input | 1 | Clears the sticky overflow status |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | 14 | Restored sample |
| out_ovf | output | 1 | Overflow flag travelling with the sample |
| ovf_sticky | output | 1 | Set once any flagged sample has been emitted |

## Verification
The bench feeds every 14-bit word through bus A in full-rate mode, once plain and once scrambled. A decoder that toggled bit 0, or that keyed its XOR off the wrong bit, would miss the odd-LSB half of the codes. It then streams thousands of pairs in demultiplexed mode and throws an extra strobe into the cycle after many of them. A design that accepted that strobe would overwrite or duplicate a pair, and one that swapped the buses or the overflow flags would emit B before A or carry the wrong flag. Mode switches are issued while a pair is still in flight, where a careless design would leak the stale bus B sample. A clear is also issued in the same cycle as a flagged sample, where a wrong priority would lose the sticky bit.

// File: rtl/adc_cap_pkg.sv
`timescale 1ns/1ps
package adc_cap_pkg;
  // Width of one converter sample
  parameter int SAMPLE_W = 14;
  // Number of parallel input buses
  parameter int NUM_BUSES = 2;

  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_DEMUX = 1'b1
  } mode_e;
endpackage

// File: rtl/adc_derand.sv
`timescale 1ns/1ps
// Reverses the LSB-keyed XOR scrambling of one bus word.
module adc_derand #(
  parameter int W = 14
) (
  input  logic         rand_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic key;

  always_comb key = rand_en & din[0];

  assign dout[0] = din[0];

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign dout[i] = din[i] ^ key;
  end
endmodule

// File: rtl/adc_cap_stage.sv
`timescale 1ns/1ps
// Capture register stage: mode tracking, strobe acceptance, pair capture.
module adc_cap_stage
  import adc_cap_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         demux_mode,
  input  logic [W-1:0] a_d,
  input  logic         a_o,
  input  logic [W-1:0] b_d,
  input  logic         b_o,
  input  logic         b_pend_i,
  output logic         s1_valid,
  output logic         s1_pair,
  output logic [W-1:0] s1_a_d,
  output logic         s1_a_o,
  output logic [W-1:0] s1_b_d,
  output logic         s1_b_o,
  output logic         mode_chg
);
  mode_e mode_q, mode_d;
  logic  accept;
  logic  pair_busy;
  logic  pipe_busy;
  logic  s1_valid_d;
  logic  s1_pair_d;

  // next-state
  always_comb begin
    mode_chg   = (mode_e'(demux_mode) != mode_q);
    pair_busy  = s1_valid & s1_pair;
    pipe_busy  = s1_valid | b_pend_i;
    accept     = cap_en & ~mode_chg & ~pair_busy;
    mode_d     = pipe_busy ? mode_q : mode_e'(demux_mode);
    s1_valid_d = accept;
    s1_pair_d  = accept ? (mode_q == MODE_DEMUX) : s1_pair;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_FULL;
      s1_valid <= 1'b0;
      s1_pair  <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      s1_valid <= s1_valid_d;
      s1_pair  <= s1_pair_d;
    end
  end

  // data registers, loaded only on an accepted capture
  always_ff @(posedge clk) begin
    if (accept) begin
      s1_a_d <= a_d;
      s1_a_o <= a_o;
      s1_b_d <= b_d;
      s1_b_o <= b_o;
    end
  end

  // R7
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(!s1_valid && !b_pend_i));
endmodule

// File: rtl/adc_merge_stage.sv
`timescale 1ns/1ps
// Output stage: emits bus A, holds bus B for the following cycle.
module adc_merge_stage #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s1_valid,
  input  logic         s1_pair,
  input  logic [W-1:0] s1_a_d,
  input  logic         s1_a_o,
  input  logic [W-1:0] s1_b_d,
  input  logic         s1_b_o,
  input  logic         mode_chg,
  output logic         b_pend,
  output logic         out_valid,
  output logic [W-1:0] out_d,
  output logic         out_o
);
  logic [W-1:0] hold_d;
  logic         hold_o;
  logic         emit_a, emit_b, load_hold;
  logic         pend_d, valid_d;
  logic [W-1:0] sel_d;
  logic         sel_o;

  // next-state
  always_comb begin
    emit_a    = s1_valid;
    emit_b    = ~s1_valid & b_pend & ~mode_chg;
    load_hold = s1_valid & s1_pair & ~mode_chg;
    pend_d    = load_hold;
    valid_d   = emit_a | emit_b;
    sel_d     = emit_a ? s1_a_d : hold_d;
    sel_o     = emit_a ? s1_a_o : hold_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_pend    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      b_pend    <= pend_d;
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_hold) begin
      hold_d <= s1_b_d;
      hold_o <= s1_b_o;
    end
  end

  always_ff @(posedge clk) begin
    if (valid_d) begin
      out_d <= sel_d;
      out_o <= sel_o;
    end
  end

  // R5
  pair_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_pend && !mode_chg) |=> out_valid);
  // R6
  slot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s1_valid, b_pend}));
endmodule

// File: rtl/adc_ovf_sticky.sv
`timescale 1ns/1ps
// Sticky out-of-range status.
module adc_ovf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic out_valid,
  input  logic out_ovf,
  input  logic ovf_clear,
  output logic ovf_sticky
);
  logic hit;
  logic sticky_d;

  always_comb begin
    hit      = out_valid & out_ovf;
    sticky_d = (ovf_sticky & ~ovf_clear) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_sticky <= 1'b0;
    else        ovf_sticky <= sticky_d;
  end

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |=> ovf_sticky);
  // R9
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clear && !(out_valid && out_ovf)) |=> !ovf_sticky);
  // R8
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_sticky) |-> $past(out_valid && out_ovf));
endmodule

// File: rtl/adc_capture_derand.sv
`timescale 1ns/1ps
module adc_capture_derand #(
  parameter int DATA_W = adc_cap_pkg::SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              demux_mode,
  input  logic              rand_en,
  input  logic [DATA_W-1:0] a_data,
  input  logic              a_ovf,
  input  logic [DATA_W-1:0] b_data,
  input  logic              b_ovf,
  input  logic              ovf_clear,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample,
  output logic              out_ovf,
  output logic              ovf_sticky
);
  localparam int LANES = adc_cap_pkg::NUM_BUSES;

  logic [LANES-1:0][DATA_W-1:0] lane_raw, lane_dec;
  logic              s1_valid, s1_pair, s1_a_o, s1_b_o, mode_chg, b_pend;
  logic [DATA_W-1:0] s1_a_d, s1_b_d;

  always_comb begin
    lane_raw[0] = a_data;
    lane_raw[1] = b_data;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    adc_derand #(.W(DATA_W)) u_derand (
      .rand_en (rand_en),
      .din     (lane_raw[l]),
      .dout    (lane_dec[l])
    );
  end

  adc_cap_stage #(.W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .demux_mode (demux_mode),
    .a_d        (lane_dec[0]),
    .a_o        (a_ovf),
    .b_d        (lane_dec[1]),
    .b_o        (b_ovf),
    .b_pend_i   (b_pend),
    .s1_valid   (s1_valid),
    .s1_pair    (s1_pair),
    .s1_a_d     (s1_a_d),
    .s1_a_o     (s1_a_o),
    .s1_b_d     (s1_b_d),
    .s1_b_o     (s1_b_o),
    .mode_chg   (mode_chg)
  );

  adc_merge_stage #(.W(DATA_W)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_pair   (s1_pair),
    .s1_a_d    (s1_a_d),
    .s1_a_o    (s1_a_o),
    .s1_b_d    (s1_b_d),
    .s1_b_o    (s1_b_o),
    .mode_chg  (mode_chg),
    .b_pend    (b_pend),
    .out_valid (out_valid),
    .out_d     (out_sample),
    .out_o     (out_ovf)
  );

  adc_ovf_sticky u_sticky (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ovf    (out_ovf),
    .ovf_clear  (ovf_clear),
    .ovf_sticky (ovf_sticky)
  );

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  // R6
  demux_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_pair) |=> !s1_valid);
endmodule

// File: tb/adc_capture_derand_test.sv
`timescale 1ns/1ps
module adc_capture_derand_test;
  localparam int W = 14;

  logic         clk;
  logic         rst_n;
  logic         cap_en, demux_mode, rand_en, a_ovf, b_ovf, ovf_clear;
  logic [W-1:0] a_data, b_data;
  logic         out_valid, out_ovf, ovf_sticky;
  logic [W-1:0] out_sample;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  bit         m_mode, m_acc1, m_acc1_pair, m_pend;
  logic [W-1:0] h_a, h_b, p_d;
  bit         h_ao, h_bo, h_rnd, p_o, p_rnd;
  bit         e_v, e_o, e_st;
  logic [W-1:0] e_d;

  adc_capture_derand uut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .demux_mode(demux_mode),
    .rand_en(rand_en), .a_data(a_data), .a_ovf(a_ovf), .b_data(b_data),
    .b_ovf(b_ovf), .ovf_clear(ovf_clear), .out_valid(out_valid),
    .out_sample(out_sample), .out_ovf(out_ovf), .ovf_sticky(ovf_sticky)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] scramble(input logic [W-1:0] x, input bit r);
    return r ? (x ^ {{(W-1){x[0]}}, 1'b0}) : x;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One clock cycle: drive, advance the model, step, compare.
  task automatic cyc(input bit cap, input bit dm, input logic [W-1:0] xa,
                     input bit oa, input logic [W-1:0] xb, input bit ob,
                     input bit rnd, input bit clr, input string tag);
    bit chg, busy, acc, v, o, r, n_st, n_pend;
    logic [W-1:0] d;
    cap_en = cap; demux_mode = dm; rand_en = rnd; ovf_clear = clr;
    a_data = scramble(xa, rnd); a_ovf = oa;
    b_data = scramble(xb, rnd); b_ovf = ob;

    chg  = (dm != m_mode);
    busy = m_acc1 | m_pend;
    acc  = cap && !chg && !(m_mode && m_acc1);
    n_st = (e_st && !clr) || (e_v && e_o);
    v = 0; o = 0; d = '0; r = 0;
    if (m_acc1) begin
      v = 1; d = h_a; o = h_ao; r = h_rnd;
    end else if (m_pend && !chg) begin
      v = 1; d = p_d; o = p_o; r = p_rnd;
    end
    n_pend = m_acc1 && m_acc1_pair && !chg;
    if (n_pend) begin
      p_d = h_b; p_o = h_bo; p_rnd = h_rnd;
    end
    m_pend      = n_pend;
    m_acc1_pair = m_mode;
    m_acc1      = acc;
    if (acc) begin
      h_a = xa; h_ao = oa; h_b = xb; h_bo = ob; h_rnd = rnd;
    end
    if (!busy) m_mode = dm;

    @(posedge clk);
    @(negedge clk);

    chk(out_valid === v, tag, "out_valid", int'(out_valid), int'(v));
    if (v) begin
      chk(out_sample === d, r ? "R3" : "R2", "out_sample", int'(out_sample), int'(d));
      chk(out_ovf === o, r ? "R3" : "R2", "out_ovf", int'(out_ovf), int'(o));
    end
    chk(ovf_sticky === n_st, clr ? "R9" : "R8", "ovf_sticky",
        int'(ovf_sticky), int'(n_st));
    e_v = v; e_o = o; e_d = d; e_st = n_st;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cap_en = 0; demux_mode = 0; rand_en = 0; ovf_clear = 0;
    a_data = '0; b_data = '0; a_ovf = 0; b_ovf = 0;
    m_mode = 0; m_acc1 = 0; m_acc1_pair = 0; m_pend = 0;
    e_v = 0; e_o = 0; e_st = 0; e_d = '0;
    h_a = '0; h_b = '0; p_d = '0; h_ao = 0; h_bo = 0; h_rnd = 0; p_o = 0; p_rnd = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(ovf_sticky === 1'b0, "R1", "ovf_sticky in reset", int'(ovf_sticky), 0);
    rst_n = 1;

    // R4 / R2: every code, full rate, plain; bus B carries decoys
    for (int i = 0; i < (1 << W); i++)
      cyc(1, 0, W'(i), (i % 97) == 5, ~W'(i), 1, 0, (i % 501) == 7, "R4");
    // R4 / R3: every code, full rate, scrambled
    for (int i = 0; i < (1 << W); i++)
      cyc(1, 0, W'(i), (i % 89) == 3, W'(i * 3), 1, 1, (i % 433) == 9, "R4");
    repeat (3) cyc(0, 0, '0, 0, '0, 0, 0, 0, "R4");

    // R7: switch to demux, strobe during pending change is ignored
    cyc(1, 1, 14'h1234, 1, 14'h0abc, 1, 0, 0, "R7");
    repeat (3) cyc(0, 1, '0, 0, '0, 0, 0, 1, "R7");

    // R5 pairs, with R6 back-to-back strobes
    for (int i = 0; i < 4096; i++) begin
      cyc(1, 1, W'(i * 5 + 1), (i % 13) == 2, W'(i * 7 + 3), (i % 11) == 4,
          i[0], (i % 97) == 1, "R5");
      cyc((i % 3) == 0, 1, W'(i * 11), 1, W'(i * 17), 1, i[1], 0, "R6");
    end
    repeat (3) cyc(0, 1, '0, 0, '0, 0, 0, 0, "R5");

    // R7: change mode while the pair sits in the capture stage
    cyc(1, 1, 14'h2aaa, 0, 14'h1555, 1, 1, 0, "R7");
    cyc(0, 0, '0, 0, '0, 0, 0, 0, "R7");
    repeat (3) cyc(0, 0, '0, 0, '0, 0, 0, 0, "R7");
    repeat (3) cyc(0, 1, '0, 0, '0, 0, 0, 0, "R7");
    // R7: change mode while bus B is pending
    cyc(1, 1, 14'h0f0f, 0, 14'h3c3c, 1, 0, 0, "R7");
    cyc(0, 1, '0, 0, '0, 0, 0, 0, "R7");
    cyc(0, 0, '0, 0, '0, 0, 0, 0, "R7");
    repeat (3) cyc(0, 0, '0, 0, '0, 0, 0, 1, "R7");

    // R9: clear collides with a flagged sample, then clears alone
    cyc(1, 0, 14'h3fff, 1, '0, 0, 0, 1, "R9");
    cyc(0, 0, '0, 0, '0, 0, 0, 1, "R9");
    cyc(0, 0, '0, 0, '0, 0, 0, 1, "R9");
    cyc(0, 0, '0, 0, '0, 0, 0, 1, "R9");
    cyc(0, 0, '0, 0, '0, 0, 0, 0, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule